// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B, and moves data across in either direction or both at once. Each side has a storage register loaded by its own capture strobe, a source select that picks between the live opposite bus and the opposite register, and an output enable. The A-to-B enable is active high and the B-to-A enable is active low. Because of this mixed polarity, one pair of control levels turns both directions on together. That pairing either swaps the two stored words across the buses or, in live mode, lets each bus re-drive the other so both keep their last value.

Each bus pin is modelled as three signals: an external input value, the block's drive value with its enable, and the resolved pin value. The resolved pin takes the block's drive when the block enables it, and the external input otherwise. The resolved value feeds the capture registers and the live pass-through path. The capture strobes are sampled on a system clock and act on their rising edges. In the live feedback configuration, two hold registers on the system clock carry the bus values forward, so the model contains no combinational loop.

Top module: `dual_bus_xcvr`

## Requirements
- R1: Every one of the W data bits is passed without inversion. With only one direction enabled and its select low, the driven pin equals the live resolved pin of the other bus in the same cycle.
- R2: The A register loads the resolved A pin on a system clock edge where `a_cap` has risen (low at the previous edge, high now). This happens whatever the selects and enables are.
- R3: The B register loads the resolved B pin in the same way on a rising `b_cap`, independent of selects and enables.
- R4: `b_oe` follows `ab_oe` (1 = B driven). While `ab_oe` is 0, `b_pin` equals `b_in`.
- R5: `a_oe` is the inverse of `ba_oe_n` (0 = A driven). While `ba_oe_n` is 1, `a_pin` equals `a_in`.
- R6: Select value 1 (`ab_sel` for B, `ba_sel` for A) makes a driven bus carry the opposite register. Select value 0 makes it carry the opposite bus live.
- R7: With `ab_oe`=1, `ba_oe_n`=0 and both selects 1, the A register appears on `b_pin` and the B register on `a_pin` in the same cycle. Pulsing both strobes in this state exchanges the two registers.
- R8: With exactly one direction enabled in live mode and both strobes pulsed, both registers load the source bus value.
- R9: With both directions enabled and both selects 0, each pin keeps its value from the previous system clock cycle, regardless of `a_in` and `b_in`.
- R10: Asynchronous active-low `rst_n` clears both storage registers and both hold registers at once. Its release is synchronised to the system clock.
- R11: A strobe held high over several clock edges loads its register only once, on the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_cap | input | 1 | Capture strobe for the A register (acts on rise) |
| b_cap | input | 1 | Capture strobe for the B register (acts on rise) |
| ab_sel | input | 1 | Source for B drive: 0 live A, 1 A register |
| ba_sel | input | 1 | Source for A drive: 0 live B, 1 B register |
| ab_oe | input | 1 | Active-high enable of the B drive |
| ba_oe_n | input | 1 | Active-low enable of the A drive |
| a_in | input | W | Value placed on bus A by other sources |
| b_in | input | W | Value placed on bus B by other sources |
| a_out | output | W | Block's drive value for bus A |
| a_oe | output | 1 | Block drives bus A |
| b_out | output | W | Block's drive value for bus B |
| b_oe | output | 1 | Block drives bus B |
| a_pin | output | W | Resolved value of bus A |
| b_pin | output | W | Resolved value of bus B |

## Verification
The bench builds the block with the default width of 8. At that width, distinct byte patterns such as 3C, A5 and C3 show whether a value came from the live bus, the A register or the B register. A single vector table therefore separates a swap from a copy and a stored transfer from a live one. The same table carries state from row to row, so the register contents loaded in one row are read back through stored-mode drive in later rows. Directed tests add a strobe held over two edges and a reset asserted while both registers hold non-zero data.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Control of one transfer direction after polarity normalisation.
  typedef struct packed {
    logic en;   // 1 = this block drives the destination bus
    logic sel;  // 1 = destination carries the opposite register
  } dir_ctrl_t;

  function automatic logic is_feedback(dir_ctrl_t to_a, dir_ctrl_t to_b);
    return to_a.en & to_b.en & ~to_a.sel & ~to_b.sel;
  endfunction
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic         cap_q;
  logic         cap_rise;
  logic [W-1:0] q_nxt;

  always_comb begin
    cap_rise = cap & ~cap_q;
    q_nxt    = cap_rise ? d : q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 1'b0;
      q     <= '0;
    end else begin
      cap_q <= cap;
      q     <= q_nxt;
    end
  end
endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  dir_ctrl_t    to_a,
  input  dir_ctrl_t    to_b,
  input  logic [W-1:0] reg_a,
  input  logic [W-1:0] reg_b,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] a_hold,
  input  logic [W-1:0] b_hold,
  output logic [W-1:0] a_pin,
  output logic [W-1:0] b_pin,
  output logic [W-1:0] a_drv,
  output logic [W-1:0] b_drv,
  output logic         loop
);
  logic [W-1:0] a_base;
  logic [W-1:0] b_base;

  always_comb begin
    loop   = is_feedback(to_a, to_b);
    // Pin value when this side is not a live copy of the other side.
    a_base = (to_a.en && to_a.sel) ? reg_b : a_in;
    b_base = (to_b.en && to_b.sel) ? reg_a : b_in;
    if (loop) begin
      a_pin = a_hold;
      b_pin = b_hold;
    end else begin
      a_pin = (to_a.en && !to_a.sel) ? b_base : a_base;
      b_pin = (to_b.en && !to_b.sel) ? a_base : b_base;
    end
    a_drv = to_a.sel ? reg_b : b_pin;
    b_drv = to_b.sel ? reg_a : a_pin;
  end
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_cap,
  input  logic         b_cap,
  input  logic         ab_sel,
  input  logic         ba_sel,
  input  logic         ab_oe,
  input  logic         ba_oe_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic [W-1:0] a_pin,
  output logic [W-1:0] b_pin
);
  logic         rst_ni;
  dir_ctrl_t    to_a;
  dir_ctrl_t    to_b;
  logic [W-1:0] reg_a;
  logic [W-1:0] reg_b;
  logic [W-1:0] a_hold;
  logic [W-1:0] b_hold;
  logic [W-1:0] a_hold_nxt;
  logic [W-1:0] b_hold_nxt;
  logic         loop;

  xcvr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  always_comb begin
    to_a.en  = ~ba_oe_n;
    to_a.sel = ba_sel;
    to_b.en  = ab_oe;
    to_b.sel = ab_sel;
  end

  xcvr_cap_reg #(.W(W)) u_reg_a (
    .clk    (clk),
    .rst_ni (rst_ni),
    .cap    (a_cap),
    .d      (a_pin),
    .q      (reg_a)
  );

  xcvr_cap_reg #(.W(W)) u_reg_b (
    .clk    (clk),
    .rst_ni (rst_ni),
    .cap    (b_cap),
    .d      (b_pin),
    .q      (reg_b)
  );

  xcvr_route #(.W(W)) u_route (
    .to_a   (to_a),
    .to_b   (to_b),
    .reg_a  (reg_a),
    .reg_b  (reg_b),
    .a_in   (a_in),
    .b_in   (b_in),
    .a_hold (a_hold),
    .b_hold (b_hold),
    .a_pin  (a_pin),
    .b_pin  (b_pin),
    .a_drv  (a_out),
    .b_drv  (b_out),
    .loop   (loop)
  );

  // Bus-keeper model: both hold registers track the resolved pins every cycle.
  always_comb begin
    a_hold_nxt = a_pin;
    b_hold_nxt = b_pin;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      a_hold <= '0;
      b_hold <= '0;
    end else begin
      a_hold <= a_hold_nxt;
      b_hold <= b_hold_nxt;
    end
  end

  assign a_oe = to_a.en;
  assign b_oe = to_b.en;
endmodule

// File: rtl/dual_bus_xcvr_chk.sv
module dual_bus_xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_ni,
  input logic         a_cap,
  input logic         b_cap,
  input logic         ab_sel,
  input logic         ab_oe,
  input logic         ba_oe_n,
  input logic         loop,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_pin,
  input logic [W-1:0] b_pin,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b
);
  AST_A_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(a_cap) |=> reg_a == $past(a_pin)); // R2
  AST_B_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(b_cap) |=> reg_b == $past(b_pin)); // R3
  AST_A_REG_KEEP: assert property (@(posedge clk) disable iff (!rst_ni)
    !$rose(a_cap) |=> $stable(reg_a)); // R11
  AST_B_EXT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_ni)
    !ab_oe |-> b_pin == b_in); // R4
  AST_A_EXT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_ni)
    ba_oe_n |-> a_pin == a_in); // R5
  AST_LIVE_AB: assert property (@(posedge clk) disable iff (!rst_ni)
    (ab_oe && !ab_sel && !loop) |-> b_pin == a_pin); // R1
  AST_STORED_AB: assert property (@(posedge clk) disable iff (!rst_ni)
    (ab_oe && ab_sel) |-> b_pin == reg_a); // R6
  AST_KEEPER: assert property (@(posedge clk) disable iff (!rst_ni)
    loop |=> (!loop || (a_pin == $past(a_pin) && b_pin == $past(b_pin)))); // R9
endmodule

bind dual_bus_xcvr dual_bus_xcvr_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_ni  (rst_ni),
  .a_cap   (a_cap),
  .b_cap   (b_cap),
  .ab_sel  (ab_sel),
  .ab_oe   (ab_oe),
  .ba_oe_n (ba_oe_n),
  .loop    (loop),
  .a_in    (a_in),
  .b_in    (b_in),
  .a_pin   (a_pin),
  .b_pin   (b_pin),
  .reg_a   (reg_a),
  .reg_b   (reg_b)
);

// File: tb/dual_bus_xcvr_test.sv
module dual_bus_xcvr_test;
  localparam int W  = 8;
  localparam int NV = 19;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         a_cap = 1'b0, b_cap = 1'b0;
  logic         ab_sel = 1'b0, ba_sel = 1'b0;
  logic         ab_oe = 1'b0, ba_oe_n = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out, a_pin, b_pin;
  logic         a_oe, b_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_bus_xcvr #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .a_cap(a_cap), .b_cap(b_cap),
    .ab_sel(ab_sel), .ba_sel(ba_sel), .ab_oe(ab_oe), .ba_oe_n(ba_oe_n),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe), .a_pin(a_pin), .b_pin(b_pin)
  );

  // Row: {ab_oe, ba_oe_n, ab_sel, ba_sel, a_cap, b_cap, a_in, b_in, exp a_pin, exp b_pin}
  localparam logic [37:0] VEC [NV] = '{
    {6'b010000, 32'h11221122},  // isolation
    {6'b010010, 32'h3C223C22},  // load A
    {6'b010001, 32'h3CA53CA5},  // load B
    {6'b111000, 32'h00FF003C},  // stored A onto B
    {6'b110000, 32'h5AFF5A5A},  // live A onto B
    {6'b000100, 32'hFF0FA50F},  // stored B onto A
    {6'b000000, 32'hFF696969},  // live B onto A
    {6'b101100, 32'h0000A53C},  // both stored
    {6'b101111, 32'h00003CA5},  // both stored, exchange
    {6'b110011, 32'hC300C3C3},  // live A onto B, load both
    {6'b111000, 32'h000000C3},  // read A register
    {6'b000100, 32'h0000C300},  // read B register
    {6'b000011, 32'h00969696},  // live B onto A, load both
    {6'b010010, 32'hE100E100},  // load A only
    {6'b101100, 32'h000096E1},  // both stored
    {6'b110000, 32'h4B004B4B},  // live A onto B
    {6'b100000, 32'h00004B4B},  // feedback, inputs released
    {6'b100011, 32'h00004B4B},  // feedback, load both
    {6'b101100, 32'h00004B4B}   // both stored after feedback load
  };

  function automatic string row_tag(int i);
    case (i)
      0:            return "R4";
      1:            return "R2";
      2:            return "R3";
      3, 10, 11:    return "R6";
      4, 6:         return "R1";
      5:            return "R5";
      7, 8, 14:     return "R7";
      9, 12, 13:    return "R8";
      default:      return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    // Reset state (R10): both stored, registers cleared
    ab_oe = 1'b1; ba_oe_n = 1'b0; ab_sel = 1'b1; ba_sel = 1'b1;
    @(negedge clk);
    chk("R10", a_pin, 8'h00, "a_pin in reset");
    chk("R10", b_pin, 8'h00, "b_pin in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      {ab_oe, ba_oe_n, ab_sel, ba_sel, a_cap, b_cap} = v[37:32];
      a_in = v[31:24];
      b_in = v[23:16];
      @(negedge clk);
      a_cap = 1'b0;
      b_cap = 1'b0;
      chk(row_tag(i), a_pin, v[15:8], $sformatf("row %0d a_pin", i));
      chk(row_tag(i), b_pin, v[7:0], $sformatf("row %0d b_pin", i));
      chk1("R5", a_oe, ~v[36], $sformatf("row %0d a_oe", i));
      chk1("R4", b_oe, v[37], $sformatf("row %0d b_oe", i));
      @(negedge clk);
    end

    // R11: strobe held high loads only on its first edge
    ab_oe = 1'b0; ba_oe_n = 1'b1; ab_sel = 1'b0; ba_sel = 1'b0;
    a_in = 8'h11; a_cap = 1'b1;
    @(negedge clk);
    a_in = 8'h22;
    @(negedge clk);
    a_cap = 1'b0;
    ab_oe = 1'b1; ab_sel = 1'b1;
    @(negedge clk);
    chk("R11", b_pin, 8'h11, "held strobe");
    chk("R11", b_out, 8'h11, "held strobe drive");

    // R10: asynchronous clear with non-zero registers
    ab_oe = 1'b1; ba_oe_n = 1'b0; ab_sel = 1'b1; ba_sel = 1'b1;
    @(negedge clk);
    chk("R10", a_pin, 8'h4B, "B register before reset");
    #2 rst_n = 1'b0;
    #1;
    chk("R10", a_pin, 8'h00, "a_pin after async reset");
    chk("R10", b_pin, 8'h00, "b_pin after async reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ab_sel = 1'b0; ba_sel = 1'b0;
    #1;
    chk("R10", a_pin, 8'h00, "hold cleared by reset");
    summary();
  end
endmodule